// File: doc/BRIEF.md
# 802.11 Receive Frame Filter

This block decides, for each received 802.11 frame, whether it goes up to the host or is discarded. Upstream logic parses the frame header and presents the frame-control type and subtype, the destination classification (unicast to this station, multicast, broadcast), a BSSID-match flag, an access-point mode flag and the FCS and ICV error flags. It asserts `frame_end` for one cycle when the whole frame has been received. The filter evaluates the frame against a 32-bit receive-control word and three 16-bit subtype bitmaps. One cycle later it presents an accept verdict and a drop reason code.

The controller has two states. `ST_IDLE` means no verdict is being presented. `ST_REPORT` means a verdict is valid this cycle. The transition EVAL (`ST_IDLE` to `ST_REPORT`) happens on `frame_end`. CHAIN (`ST_REPORT` to `ST_REPORT`) happens when a new `frame_end` arrives while a verdict is shown. RETIRE (`ST_REPORT` to `ST_IDLE`) happens when no new frame ends. The `accept` and `drop_reason` outputs hold their last values between verdicts.

Top module: `rxflt_top`

## Requirements
- R1: `verdict_valid` is high in exactly the cycle after each cycle with `frame_end` high, and low otherwise. `accept` and `drop_reason` take the new verdict in that same cycle and hold it until the next one. Right after reset, `verdict_valid`, `accept` and `drop_reason` are all 0.
- R2: A frame with `fcs_err` set is dropped unless control bit 8 is set. A frame with `icv_err` set is dropped unless control bit 9 is set. The drop reason code is 1.
- R3: A broadcast frame (`is_bcast`) needs control bit 3. A multicast frame that is not broadcast needs bit 2. Any other frame needs `uc_self` or control bit 0. A failure gives reason code 2.
- R4: When control bit 6 is set, data frames (type 2) need `bssid_match`. When control bit 7 is set, beacons (type 0, subtype 8) need `bssid_match`. Bit 6 has no effect on management frames. A failure gives reason code 2.
- R5: Management frames (type 0) need control bit 13, control frames (type 1) need bit 12, and data frames (type 2) need bit 11. Type 3 frames are always dropped. A failure gives reason code 3.
- R6: Control subtypes 8 (block-ack request) and 9 (block ack) are enabled by bit 11 and ignore bit 12. Subtype 10 (PS-Poll) is treated the same way only when `ap_mode` is 1. With `ap_mode` at 0, PS-Poll follows bit 12.
- R7: A frame passes only if bit `fc_subtype` of the bitmap for its type is set. `mgmt_map` covers type 0, `ctrl_map` covers type 1 and `data_map` covers type 2. A failure gives reason code 4.
- R8: A frame is accepted (`accept`=1, reason 0) only when all checks pass. When several checks fail, the reported reason follows the priority error > address > type > subtype.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_end | input | 1 | One-cycle strobe: frame fields below are valid |
| fc_type | input | 2 | Frame-control type |
| fc_subtype | input | 4 | Frame-control subtype |
| ap_mode | input | 1 | Station operates as access point |
| uc_self | input | 1 | Destination address equals own address |
| is_mcast | input | 1 | Destination is a group address |
| is_bcast | input | 1 | Destination is the broadcast address |
| bssid_match | input | 1 | BSSID equals the configured BSSID |
| fcs_err | input | 1 | Frame check sequence failed |
| icv_err | input | 1 | Integrity check value failed |
| rx_ctrl | input | 32 | Receive-control word |
| mgmt_map | input | 16 | Per-subtype pass bits, management |
| ctrl_map | input | 16 | Per-subtype pass bits, control |
| data_map | input | 16 | Per-subtype pass bits, data |
| verdict_valid | output | 1 | Verdict present this cycle |
| accept | output | 1 | Frame goes to host |
| drop_reason | output | 3 | 0 none, 1 error, 2 address, 3 type, 4 subtype |

## Verification
The bench builds the block with its default parameters: a 32-bit control word and a 4-bit subtype, which gives 16-entry bitmaps. With these values every subtype position can be reached, including the top entry 15 and the control subtypes 8 to 10 that switch enable bits. Each control bit the filter reads sits inside the word, so the bench can clear each one individually and combine several to exercise the reason priority. Back-to-back frame-end strobes exercise the CHAIN transition.

// File: rtl/rxflt_pkg.sv
package rxflt_pkg;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_ERR     = 3'd1,
        RSN_ADDR    = 3'd2,
        RSN_TYPE    = 3'd3,
        RSN_SUBTYPE = 3'd4
    } reason_e;

    typedef enum logic [1:0] {
        FT_MGMT = 2'd0,
        FT_CTRL = 2'd1,
        FT_DATA = 2'd2,
        FT_RSVD = 2'd3
    } ftype_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    // receive-control word bit positions
    localparam int unsigned CB_UC_ALL   = 0;
    localparam int unsigned CB_MCAST    = 2;
    localparam int unsigned CB_BCAST    = 3;
    localparam int unsigned CB_BSS_DATA = 6;
    localparam int unsigned CB_BSS_BCN  = 7;
    localparam int unsigned CB_FCS_OK   = 8;
    localparam int unsigned CB_ICV_OK   = 9;
    localparam int unsigned CB_EN_DATA  = 11;
    localparam int unsigned CB_EN_CTRL  = 12;
    localparam int unsigned CB_EN_MGMT  = 13;

    // subtype codes with special handling
    localparam int unsigned SUB_BEACON = 8;
    localparam int unsigned SUB_BAR    = 8;
    localparam int unsigned SUB_BA     = 9;
    localparam int unsigned SUB_PSPOLL = 10;

endpackage

// File: rtl/rxflt_addr_chk.sv
module rxflt_addr_chk
    import rxflt_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int SUB_W  = 4
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [1:0]        fc_type,
    input  logic [SUB_W-1:0]  fc_subtype,
    input  logic              uc_self,
    input  logic              is_mcast,
    input  logic              is_bcast,
    input  logic              bssid_match,
    output logic              addr_ok
);

    logic dest_ok;
    logic is_data;
    logic is_beacon;
    logic bss_ok;
    logic unused_cfg;

    assign unused_cfg = ^ctrl;
    assign is_data    = (fc_type == FT_DATA);
    assign is_beacon  = (fc_type == FT_MGMT) && (fc_subtype == SUB_W'(SUB_BEACON));

    always_comb begin
        if (is_bcast)
            dest_ok = ctrl[CB_BCAST];
        else if (is_mcast)
            dest_ok = ctrl[CB_MCAST];
        else
            dest_ok = uc_self || ctrl[CB_UC_ALL];
    end

    assign bss_ok = !(is_data   && ctrl[CB_BSS_DATA] && !bssid_match) &&
                    !(is_beacon && ctrl[CB_BSS_BCN]  && !bssid_match);

    assign addr_ok = dest_ok && bss_ok;

endmodule

// File: rtl/rxflt_type_gate.sv
module rxflt_type_gate
    import rxflt_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int SUB_W  = 4,
    localparam int MAP_W = 1 << SUB_W
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [1:0]        fc_type,
    input  logic [SUB_W-1:0]  fc_subtype,
    input  logic              ap_mode,
    input  logic [MAP_W-1:0]  mgmt_map,
    input  logic [MAP_W-1:0]  ctrl_map,
    input  logic [MAP_W-1:0]  data_map,
    output logic              type_ok,
    output logic              sub_ok
);

    logic             data_class_ctrl;
    logic [MAP_W-1:0] sel_map;
    logic             unused_cfg;

    assign unused_cfg = ^ctrl;

    // control subtypes that follow the data-enable bit
    assign data_class_ctrl = (fc_subtype == SUB_W'(SUB_BAR)) ||
                             (fc_subtype == SUB_W'(SUB_BA))  ||
                             ((fc_subtype == SUB_W'(SUB_PSPOLL)) && ap_mode);

    always_comb begin
        type_ok = 1'b0;
        sel_map = '0;
        unique case (fc_type)
            FT_MGMT: begin
                type_ok = ctrl[CB_EN_MGMT];
                sel_map = mgmt_map;
            end
            FT_CTRL: begin
                type_ok = data_class_ctrl ? ctrl[CB_EN_DATA] : ctrl[CB_EN_CTRL];
                sel_map = ctrl_map;
            end
            FT_DATA: begin
                type_ok = ctrl[CB_EN_DATA];
                sel_map = data_map;
            end
            FT_RSVD: begin
                type_ok = 1'b0;
                sel_map = '0;
            end
        endcase
    end

    assign sub_ok = sel_map[fc_subtype];

endmodule

// File: rtl/rxflt_top.sv
module rxflt_top
    import rxflt_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int SUB_W  = 4,
    localparam int MAP_W = 1 << SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [1:0]        fc_type,
    input  logic [SUB_W-1:0]  fc_subtype,
    input  logic              ap_mode,
    input  logic              uc_self,
    input  logic              is_mcast,
    input  logic              is_bcast,
    input  logic              bssid_match,
    input  logic              fcs_err,
    input  logic              icv_err,
    input  logic [CTRL_W-1:0] rx_ctrl,
    input  logic [MAP_W-1:0]  mgmt_map,
    input  logic [MAP_W-1:0]  ctrl_map,
    input  logic [MAP_W-1:0]  data_map,
    output logic              verdict_valid,
    output logic              accept,
    output logic [2:0]        drop_reason
);

    state_e  state_q, state_d;
    reason_e reason_d, reason_q;
    logic    accept_q;
    logic    err_ok, addr_ok, type_ok, sub_ok;

    assign err_ok = !(fcs_err && !rx_ctrl[CB_FCS_OK]) &&
                    !(icv_err && !rx_ctrl[CB_ICV_OK]);

    rxflt_addr_chk #(.CTRL_W(CTRL_W), .SUB_W(SUB_W)) addr_i (
        .ctrl        (rx_ctrl),
        .fc_type     (fc_type),
        .fc_subtype  (fc_subtype),
        .uc_self     (uc_self),
        .is_mcast    (is_mcast),
        .is_bcast    (is_bcast),
        .bssid_match (bssid_match),
        .addr_ok     (addr_ok)
    );

    rxflt_type_gate #(.CTRL_W(CTRL_W), .SUB_W(SUB_W)) type_i (
        .ctrl       (rx_ctrl),
        .fc_type    (fc_type),
        .fc_subtype (fc_subtype),
        .ap_mode    (ap_mode),
        .mgmt_map   (mgmt_map),
        .ctrl_map   (ctrl_map),
        .data_map   (data_map),
        .type_ok    (type_ok),
        .sub_ok     (sub_ok)
    );

    // priority: error, address, type, subtype
    always_comb begin
        if (!err_ok)
            reason_d = RSN_ERR;
        else if (!addr_ok)
            reason_d = RSN_ADDR;
        else if (!type_ok)
            reason_d = RSN_TYPE;
        else if (!sub_ok)
            reason_d = RSN_SUBTYPE;
        else
            reason_d = RSN_NONE;
    end

    // next state: EVAL, CHAIN, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frame_end ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = frame_end ? ST_REPORT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            reason_q <= RSN_NONE;
        end else if (frame_end) begin
            accept_q <= (reason_d == RSN_NONE);
            reason_q <= reason_d;
        end
    end

    assign verdict_valid = (state_q == ST_REPORT);
    assign accept        = accept_q;
    assign drop_reason   = reason_q;

endmodule

// File: rtl/rxflt_chk.sv
module rxflt_chk #(
    parameter int CTRL_W = 32,
    parameter int SUB_W  = 4,
    localparam int MAP_W = 1 << SUB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic [1:0]        fc_type,
    input logic [SUB_W-1:0]  fc_subtype,
    input logic              is_bcast,
    input logic              fcs_err,
    input logic [CTRL_W-1:0] rx_ctrl,
    input logic [MAP_W-1:0]  data_map,
    input logic              verdict_valid,
    input logic              accept,
    input logic [2:0]        drop_reason
);

    logic unused_cfg;
    assign unused_cfg = ^rx_ctrl;

    // R1
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> verdict_valid);

    // R1
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> !verdict_valid);

    // R8
    acc_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> (accept == (drop_reason == 3'd0)));

    // R2
    fcs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && fcs_err && !rx_ctrl[8]) |=> (!accept && drop_reason == 3'd1));

    // R3
    bcast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && is_bcast && !rx_ctrl[3]) |=> !accept);

    // R5
    rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && fc_type == 2'd3) |=> !accept);

    // R7
    map_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && fc_type == 2'd2 && !data_map[fc_subtype]) |=> !accept);

endmodule

bind rxflt_top rxflt_chk #(.CTRL_W(CTRL_W), .SUB_W(SUB_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_end     (frame_end),
    .fc_type       (fc_type),
    .fc_subtype    (fc_subtype),
    .is_bcast      (is_bcast),
    .fcs_err       (fcs_err),
    .rx_ctrl       (rx_ctrl),
    .data_map      (data_map),
    .verdict_valid (verdict_valid),
    .accept        (accept),
    .drop_reason   (drop_reason)
);

// File: tb/rxflt_top_tb_top.sv
module rxflt_top_tb_top;

    localparam logic [31:0] BASE_CTRL = 32'h0000_380C; // bits 2,3,11,12,13

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_end = 1'b0;
    logic [1:0]  fc_type = 2'd2;
    logic [3:0]  fc_subtype = 4'd0;
    logic        ap_mode = 1'b0;
    logic        uc_self = 1'b1;
    logic        is_mcast = 1'b0;
    logic        is_bcast = 1'b0;
    logic        bssid_match = 1'b1;
    logic        fcs_err = 1'b0;
    logic        icv_err = 1'b0;
    logic [31:0] rx_ctrl = BASE_CTRL;
    logic [15:0] mgmt_map = 16'hFFFF;
    logic [15:0] ctrl_map = 16'hFFFF;
    logic [15:0] data_map = 16'hFFFF;
    logic        verdict_valid;
    logic        accept;
    logic [2:0]  drop_reason;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rxflt_top dut_i (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
        .fc_type(fc_type), .fc_subtype(fc_subtype), .ap_mode(ap_mode),
        .uc_self(uc_self), .is_mcast(is_mcast), .is_bcast(is_bcast),
        .bssid_match(bssid_match), .fcs_err(fcs_err), .icv_err(icv_err),
        .rx_ctrl(rx_ctrl), .mgmt_map(mgmt_map), .ctrl_map(ctrl_map),
        .data_map(data_map), .verdict_valid(verdict_valid),
        .accept(accept), .drop_reason(drop_reason)
    );

    task automatic defaults();
        fc_type = 2'd2; fc_subtype = 4'd0; ap_mode = 1'b0;
        uc_self = 1'b1; is_mcast = 1'b0; is_bcast = 1'b0; bssid_match = 1'b1;
        fcs_err = 1'b0; icv_err = 1'b0; rx_ctrl = BASE_CTRL;
        mgmt_map = 16'hFFFF; ctrl_map = 16'hFFFF; data_map = 16'hFFFF;
    endtask

    task automatic verify(input logic vld, input logic acc, input logic [2:0] rsn,
                          input string tag);
        n_chk++;
        if (verdict_valid !== vld || accept !== acc || drop_reason !== rsn) begin
            n_fail++;
            $display("FAIL %s: valid=%0d accept=%0d reason=%0d expected valid=%0d accept=%0d reason=%0d",
                     tag, verdict_valid, accept, drop_reason, vld, acc, rsn);
        end
    endtask

    // one frame_end pulse; sample just after the edge that registers it
    task automatic fire(input logic acc, input logic [2:0] rsn, input string tag);
        @(negedge clk);
        frame_end = 1'b1;
        @(posedge clk);
        #1;
        frame_end = 1'b0;
        verify(1'b1, acc, rsn, tag);
    endtask

    task automatic t_reset();
        verify(1'b0, 1'b0, 3'd0, "R1 reset");
    endtask

    task automatic t_basic();
        defaults();
        fire(1'b1, 3'd0, "R8 unicast data accept");
        @(posedge clk); #1;
        verify(1'b0, 1'b1, 3'd0, "R1 verdict drops and holds");
    endtask

    task automatic t_errors();
        defaults(); fcs_err = 1'b1;
        fire(1'b0, 3'd1, "R2 fcs dropped");
        rx_ctrl[8] = 1'b1;
        fire(1'b1, 3'd0, "R2 fcs allowed");
        defaults(); icv_err = 1'b1;
        fire(1'b0, 3'd1, "R2 icv dropped");
        rx_ctrl[9] = 1'b1;
        fire(1'b1, 3'd0, "R2 icv allowed");
    endtask

    task automatic t_addr();
        defaults(); is_bcast = 1'b1; is_mcast = 1'b1; uc_self = 1'b0; rx_ctrl[3] = 1'b0;
        fire(1'b0, 3'd2, "R3 broadcast blocked");
        defaults(); is_mcast = 1'b1; uc_self = 1'b0; rx_ctrl[2] = 1'b0;
        fire(1'b0, 3'd2, "R3 multicast blocked");
        defaults(); uc_self = 1'b0;
        fire(1'b0, 3'd2, "R3 foreign unicast blocked");
        rx_ctrl[0] = 1'b1;
        fire(1'b1, 3'd0, "R3 accept-all unicast");
    endtask

    task automatic t_bssid();
        defaults(); rx_ctrl[6] = 1'b1; bssid_match = 1'b0;
        fire(1'b0, 3'd2, "R4 data bssid required");
        defaults(); fc_type = 2'd0; fc_subtype = 4'd8; rx_ctrl[7] = 1'b1; bssid_match = 1'b0;
        fire(1'b0, 3'd2, "R4 beacon bssid required");
        defaults(); fc_type = 2'd0; fc_subtype = 4'd8; rx_ctrl[6] = 1'b1; bssid_match = 1'b0;
        fire(1'b1, 3'd0, "R4 data bssid bit ignores beacon");
    endtask

    task automatic t_types();
        defaults(); fc_type = 2'd0; fc_subtype = 4'd4; rx_ctrl[13] = 1'b0;
        fire(1'b0, 3'd3, "R5 management disabled");
        defaults(); fc_type = 2'd1; fc_subtype = 4'd11; rx_ctrl[12] = 1'b0;
        fire(1'b0, 3'd3, "R5 control disabled");
        defaults(); rx_ctrl[11] = 1'b0;
        fire(1'b0, 3'd3, "R5 data disabled");
        defaults(); fc_type = 2'd3; rx_ctrl = 32'hFFFF_FFFF;
        fire(1'b0, 3'd3, "R5 reserved type");
    endtask

    task automatic t_ba();
        defaults(); fc_type = 2'd1; fc_subtype = 4'd9; rx_ctrl[12] = 1'b0;
        fire(1'b1, 3'd0, "R6 block ack via data bit");
        defaults(); fc_type = 2'd1; fc_subtype = 4'd8; rx_ctrl[11] = 1'b0;
        fire(1'b0, 3'd3, "R6 bar needs data bit");
        defaults(); fc_type = 2'd1; fc_subtype = 4'd10; ap_mode = 1'b1; rx_ctrl[12] = 1'b0;
        fire(1'b1, 3'd0, "R6 ps-poll ap mode");
        ap_mode = 1'b0;
        fire(1'b0, 3'd3, "R6 ps-poll station mode");
    endtask

    task automatic t_subtype();
        defaults(); data_map[4] = 1'b0; fc_subtype = 4'd4;
        fire(1'b0, 3'd4, "R7 data subtype masked");
        fc_subtype = 4'd5;
        fire(1'b1, 3'd0, "R7 data neighbour subtype");
        defaults(); mgmt_map[15] = 1'b0; fc_type = 2'd0; fc_subtype = 4'd15;
        fire(1'b0, 3'd4, "R7 mgmt subtype 15 masked");
        fc_type = 2'd2;
        fire(1'b1, 3'd0, "R7 other type map unaffected");
    endtask

    task automatic t_prio();
        defaults(); fcs_err = 1'b1; is_bcast = 1'b1; rx_ctrl[3] = 1'b0; rx_ctrl[11] = 1'b0;
        data_map = 16'h0000;
        fire(1'b0, 3'd1, "R8 error first");
        fcs_err = 1'b0;
        fire(1'b0, 3'd2, "R8 address second");
        is_bcast = 1'b0;
        fire(1'b0, 3'd3, "R8 type third");
    endtask

    task automatic t_b2b();
        defaults();
        @(negedge clk);
        frame_end = 1'b1;
        @(posedge clk); #1;
        verify(1'b1, 1'b1, 3'd0, "R1 back-to-back first");
        fcs_err = 1'b1;
        @(posedge clk); #1;
        frame_end = 1'b0;
        verify(1'b1, 1'b0, 3'd1, "R1 back-to-back second");
        @(posedge clk); #1;
        verify(1'b0, 1'b0, 3'd1, "R1 back-to-back retire");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run incomplete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_errors();
        t_addr();
        t_bssid();
        t_types();
        t_ba();
        t_subtype();
        t_prio();
        t_b2b();
        finish_run();
    end

endmodule